// File: doc/BRIEF.md
# Dual-Rail Elastic Jitter Buffer

This block is an elastic store that sits on the receive path of a bipolar line interface and smooths out phase wander on the recovered line clock. Every falling edge of the recovered clock writes one entry that holds a positive-rail bit and a negative-rail bit. A read controller in the local reference-clock domain empties the store at one quarter of the reference rate. It produces a steady output clock and output rails that change only on the rising edge of that clock. The reference clock is four times the nominal line rate, so reads and writes balance on average.

The write pointer crosses into the reference domain as a Gray code through two flops. The fill level is computed there from the synchronized write pointer and the read pointer. Two status outputs are derived from the fill level. The limit flag is raised when the store is close to full or close to empty. The steering output is high while the fill is above the midpoint, so an external loop can nudge the reference frequency.

A depth-select input picks a usable depth of 128 or 32 entries, and the limit margin follows the chosen depth. A falling edge on the recenter input moves the read pointer to half the selected depth behind the write pointer. A bypass input routes the raw line clock and rails straight to the outputs.

The read controller is a three-state machine:
- PRIME holds the output clock low and waits for the fill to reach half the selected depth.
- RUN reads one entry every four reference cycles.
- RECENTER lasts one cycle and realigns the read pointer.

Its transitions are:
- PRIME→RUN when the fill reaches half depth.
- RUN→PRIME when a read slot finds the store empty.
- PRIME→RECENTER and RUN→RECENTER on a recenter falling edge.
- RECENTER→RUN unconditionally.

Top module: `jitter_buf`

## Requirements
- R1: Each entry holds the positive-rail and negative-rail bits sampled together on the falling edge of `line_clk_i`. Entries leave in the same order in which they were written, one entry per output clock.
- R2: While running, the output clock has a period of 4 reference cycles and is high for 2 of them. Both output rails change only on its rising edge.
- R3: After reset, and whenever the store has run empty, the output clock stays low until the fill reaches half the selected depth. The first entry read after reset is the first entry written, so the latency is about half the depth in line bits.
- R4: `depth_sel_i` = 0 selects a depth of 128 (half depth 64). `depth_sel_i` = 1 selects a depth of 32 (half depth 16).
- R5: `limit_o` is high when the fill is ≤4 or ≥124 at depth 128, or ≤2 or ≥30 at depth 32. Otherwise it is low.
- R6: A high-to-low transition on `recenter_i` sets the fill to half the selected depth. Data passing through at that moment may be corrupted.
- R7: While `bypass_i` is 1, `out_clk_o`, `out_pos_o` and `out_neg_o` equal `line_clk_i`, `line_pos_i` and `line_neg_i` with no storage in between.
- R8: `steer_up_o` is high when the fill is above half the selected depth, and low when it is at or below half depth.
- R9: The write pointer reaches the reference domain as a Gray code through two flops, so the synchronized value changes by at most one bit per reference cycle.
- R10: When a read slot finds the store empty, the controller returns to PRIME and the output clock stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock, 4x the line rate |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| line_clk_i | input | 1 | Recovered, jittered line clock |
| line_pos_i | input | 1 | Positive-rail data, sampled on the falling line-clock edge |
| line_neg_i | input | 1 | Negative-rail data, sampled on the falling line-clock edge |
| depth_sel_i | input | 1 | 0 selects depth 128, 1 selects depth 32 |
| recenter_i | input | 1 | Recenters the store on a high-to-low transition |
| bypass_i | input | 1 | 1 routes the line inputs straight to the outputs |
| out_clk_o | output | 1 | Dejittered output clock |
| out_pos_o | output | 1 | Dejittered positive-rail data |
| out_neg_o | output | 1 | Dejittered negative-rail data |
| limit_o | output | 1 | Near-full or near-empty indication |
| steer_up_o | output | 1 | Fill above the midpoint |

## Verification
The assertions assume that the line clock is never faster than one quarter of the reference clock plus the jitter swing. Under that assumption the write pointer advances at most once per reference cycle. They also assume that `depth_sel_i` changes only while reset is held, and that a recenter pulse is wider than two reference cycles. The stimulus keeps within these bounds:
- The line period is 40 ns with a sinusoid-like swing of at most 8 ns, and the fast-line runs use 36 ns.
- The depth is changed only inside reset.
- The recenter pulse lasts three reference cycles.

// File: rtl/jb_pkg.sv
package jb_pkg;

    typedef enum logic [1:0] {
        ST_PRIME    = 2'd0,
        ST_RUN      = 2'd1,
        ST_RECENTER = 2'd2
    } rd_state_t;

    typedef struct packed {
        logic pos;
        logic neg;
    } rail_pair_t;

endpackage

// File: rtl/jb_sync2.sv
module jb_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;

endmodule

// File: rtl/jb_wr_side.sv
module jb_wr_side
    import jb_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int AW    = 7,
    parameter int PW    = 8
) (
    input  logic          lclk,
    input  logic          rst_n,
    input  rail_pair_t    din,
    input  logic [AW-1:0] raddr,
    output rail_pair_t    rdata,
    output logic [PW-1:0] wgray_o
);

    rail_pair_t    store [DEPTH];
    logic [PW-1:0] wbin_q;
    logic [PW-1:0] wbin_d;
    logic [PW-1:0] wgray_q;

    assign wbin_d = wbin_q + PW'(1);

    // pointer and its Gray image advance together on the falling line edge
    always_ff @(negedge lclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
        end else begin
            wbin_q  <= wbin_d;
            wgray_q <= wbin_d ^ (wbin_d >> 1);
        end
    end

    always_ff @(negedge lclk) begin
        store[wbin_q[AW-1:0]] <= din;
    end

    assign rdata   = store[raddr];
    assign wgray_o = wgray_q;

endmodule

// File: rtl/jb_level.sv
module jb_level #(
    parameter int PW           = 8,
    parameter int FULL_DEPTH   = 128,
    parameter int SMALL_DEPTH  = 32,
    parameter int FULL_MARGIN  = 4,
    parameter int SMALL_MARGIN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dsel,
    input  logic [PW-1:0] wbin_s,
    input  logic [PW-1:0] rptr,
    output logic [PW-1:0] fill_o,
    output logic          limit_o,
    output logic          steer_o
);

    localparam logic [PW-1:0] SPAN_F = PW'(FULL_DEPTH);
    localparam logic [PW-1:0] SPAN_S = PW'(SMALL_DEPTH);
    localparam logic [PW-1:0] MARG_F = PW'(FULL_MARGIN);
    localparam logic [PW-1:0] MARG_S = PW'(SMALL_MARGIN);

    logic [PW-1:0] margin;
    logic [PW-1:0] span;
    logic [PW-1:0] half;
    logic          near_edge;
    logic          limit_q;
    logic          steer_q;

    assign fill_o = wbin_s - rptr;

    always_comb begin
        if (dsel) begin
            margin = MARG_S;
            span   = SPAN_S;
        end else begin
            margin = MARG_F;
            span   = SPAN_F;
        end
        half      = span >> 1;
        near_edge = (fill_o <= margin) || (fill_o >= span - margin);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= 1'b0;
            steer_q <= 1'b0;
        end else begin
            limit_q <= near_edge;
            steer_q <= fill_o > half;
        end
    end

    assign limit_o = limit_q;
    assign steer_o = steer_q;

endmodule

// File: rtl/jb_rd_ctrl.sv
module jb_rd_ctrl
    import jb_pkg::*;
#(
    parameter int PW          = 8,
    parameter int AW          = 7,
    parameter int FULL_DEPTH  = 128,
    parameter int SMALL_DEPTH = 32,
    parameter int REF_DIV     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dsel,
    input  logic          recenter_s,
    input  logic [PW-1:0] wgray_s,
    input  logic [PW-1:0] fill,
    input  rail_pair_t    rdata,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] wbin_s,
    output logic [PW-1:0] rptr_o,
    output logic          oclk_o,
    output rail_pair_t    rail_o
);

    localparam int            PH_W   = $clog2(REF_DIV);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(REF_DIV - 1);
    localparam logic [PH_W-1:0] PH_READ = PH_W'(REF_DIV / 2 - 1);
    localparam logic [PH_W-1:0] PH_HIGH = PH_W'(REF_DIV / 2);
    localparam logic [PW-1:0] HALF_F = PW'(FULL_DEPTH / 2);
    localparam logic [PW-1:0] HALF_S = PW'(SMALL_DEPTH / 2);

    rd_state_t       state_q, state_d;
    logic            rc_prev_q;
    logic            rc_fall;
    logic [PH_W-1:0] phase_q, phase_d;
    logic [PW-1:0]   rptr_q, rptr_d;
    rail_pair_t      rail_q, rail_d;
    logic            oclk_q;
    logic            rd_slot;
    logic            empty;
    logic [PW-1:0]   half;

    // Gray to binary: each bit is the parity of itself and all higher bits
    always_comb begin
        for (int i = 0; i < PW; i++) begin
            wbin_s[i] = ^(wgray_s >> i);
        end
    end

    assign half    = dsel ? HALF_S : HALF_F;
    assign rc_fall = rc_prev_q & ~recenter_s;
    assign rd_slot = (state_q == ST_RUN) && (phase_q == PH_READ);
    assign empty   = (fill == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: begin
                if (rc_fall)           state_d = ST_RECENTER;
                else if (fill >= half) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (rc_fall)                state_d = ST_RECENTER;
                else if (rd_slot && empty)  state_d = ST_PRIME;
            end
            ST_RECENTER: state_d = ST_RUN;
            default:     state_d = ST_PRIME;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_PRIME;
            rc_prev_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            rc_prev_q <= recenter_s;
        end
    end

    // datapath next values per state
    always_comb begin
        phase_d = phase_q;
        rptr_d  = rptr_q;
        rail_d  = rail_q;
        unique case (state_q)
            ST_PRIME: phase_d = '0;
            ST_RUN: begin
                if (rd_slot && empty) begin
                    phase_d = '0;
                end else begin
                    phase_d = (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
                    if (rd_slot) begin
                        rail_d = rdata;
                        rptr_d = rptr_q + PW'(1);
                    end
                end
            end
            ST_RECENTER: begin
                phase_d = '0;
                rptr_d  = wbin_s - half;
            end
            default: phase_d = '0;
        endcase
    end

    // output registers: clock, rails and read pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            rptr_q  <= '0;
            rail_q  <= '0;
            oclk_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            rptr_q  <= rptr_d;
            rail_q  <= rail_d;
            oclk_q  <= (phase_d >= PH_HIGH);
        end
    end

    assign raddr  = rptr_q[AW-1:0];
    assign rptr_o = rptr_q;
    assign oclk_o = oclk_q;
    assign rail_o = rail_q;

    AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_RUN) |-> ((rptr_q - $past(rptr_q)) <= PW'(1))); // R1

    AST_READ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_RUN && rptr_q != $past(rptr_q)) |-> $rose(oclk_q)); // R2

    AST_PRIME_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIME) |-> !oclk_q); // R3

    AST_RECENTER_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECENTER) |=> ((fill - half) <= PW'(1))); // R6

    AST_GRAY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray_s ^ $past(wgray_s)) <= 1); // R9

endmodule

// File: rtl/jitter_buf.sv
module jitter_buf
    import jb_pkg::*;
#(
    parameter int FULL_DEPTH   = 128,
    parameter int SMALL_DEPTH  = 32,
    parameter int FULL_MARGIN  = 4,
    parameter int SMALL_MARGIN = 2,
    parameter int REF_DIV      = 4
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic line_clk_i,
    input  logic line_pos_i,
    input  logic line_neg_i,
    input  logic depth_sel_i,
    input  logic recenter_i,
    input  logic bypass_i,
    output logic out_clk_o,
    output logic out_pos_o,
    output logic out_neg_o,
    output logic limit_o,
    output logic steer_up_o
);

    localparam int AW = $clog2(FULL_DEPTH);
    localparam int PW = AW + 1;

    rail_pair_t    din;
    rail_pair_t    rdata;
    rail_pair_t    rail_q;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wgray;
    logic [PW-1:0] wgray_s;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] rptr;
    logic [PW-1:0] fill;
    logic          rc_s;
    logic          oclk;

    assign din.pos = line_pos_i;
    assign din.neg = line_neg_i;

    jb_wr_side #(
        .DEPTH (FULL_DEPTH),
        .AW    (AW),
        .PW    (PW)
    ) wr_i (
        .lclk    (line_clk_i),
        .rst_n   (rst_n),
        .din     (din),
        .raddr   (raddr),
        .rdata   (rdata),
        .wgray_o (wgray)
    );

    jb_sync2 #(.W(PW)) wsync_i (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    jb_sync2 #(.W(1)) rcsync_i (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (recenter_i),
        .q     (rc_s)
    );

    jb_rd_ctrl #(
        .PW          (PW),
        .AW          (AW),
        .FULL_DEPTH  (FULL_DEPTH),
        .SMALL_DEPTH (SMALL_DEPTH),
        .REF_DIV     (REF_DIV)
    ) rd_i (
        .clk        (ref_clk),
        .rst_n      (rst_n),
        .dsel       (depth_sel_i),
        .recenter_s (rc_s),
        .wgray_s    (wgray_s),
        .fill       (fill),
        .rdata      (rdata),
        .raddr      (raddr),
        .wbin_s     (wbin_s),
        .rptr_o     (rptr),
        .oclk_o     (oclk),
        .rail_o     (rail_q)
    );

    jb_level #(
        .PW           (PW),
        .FULL_DEPTH   (FULL_DEPTH),
        .SMALL_DEPTH  (SMALL_DEPTH),
        .FULL_MARGIN  (FULL_MARGIN),
        .SMALL_MARGIN (SMALL_MARGIN)
    ) lvl_i (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .dsel    (depth_sel_i),
        .wbin_s  (wbin_s),
        .rptr    (rptr),
        .fill_o  (fill),
        .limit_o (limit_o),
        .steer_o (steer_up_o)
    );

    // bypass path: raw line signals straight through
    assign out_clk_o = bypass_i ? line_clk_i : oclk;
    assign out_pos_o = bypass_i ? line_pos_i : rail_q.pos;
    assign out_neg_o = bypass_i ? line_neg_i : rail_q.neg;

endmodule

// File: tb/jitter_buf_tb_top.sv
`timescale 1ns/1ps
module jitter_buf_tb_top;

    localparam int MEMN = 8192;
    localparam int JIT [16] = '{0, 3, 6, 8, 8, 6, 3, 0, 0, -3, -6, -8, -8, -6, -3, 0};
    // bypass vectors {clk, pos, neg}; expected outputs equal the inputs
    localparam logic [2:0] BYP_VEC [4] = '{3'b101, 3'b010, 3'b111, 3'b000};

    logic ref_clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_clk = 1'b0;
    logic line_pos = 1'b0;
    logic line_neg = 1'b0;
    logic depth_sel = 1'b0;
    logic recenter = 1'b0;
    logic bypass = 1'b0;
    logic out_clk, out_pos, out_neg, limit_w, steer_w;

    int n_chk = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int rise_cnt = 0;
    int est = 0;
    int first_lat = -1;
    int stream_n = 0, stream_err = 0, band_n = 0, band_err = 0;
    int half = 64, lo_ok = 6, hi_ok = 122, hard_hi = 126;
    bit lc_en = 0, mon_en = 0, chk_stream = 0, band_en = 0;
    bit seen_lim = 0, seen_steer = 0;
    int base_per = 40;
    int jscale = 1;
    logic [15:0] lf = 16'hACE1;
    logic in_pos [MEMN];
    logic in_neg [MEMN];

    jitter_buf dut_i (
        .ref_clk     (ref_clk),
        .rst_n       (rst_n),
        .line_clk_i  (line_clk),
        .line_pos_i  (line_pos),
        .line_neg_i  (line_neg),
        .depth_sel_i (depth_sel),
        .recenter_i  (recenter),
        .bypass_i    (bypass),
        .out_clk_o   (out_clk),
        .out_pos_o   (out_pos),
        .out_neg_o   (out_neg),
        .limit_o     (limit_w),
        .steer_up_o  (steer_w)
    );

    always #5 ref_clk = ~ref_clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // jittered line clock: period walks the jitter table
    initial begin
        int jidx = 0;
        forever begin
            if (lc_en) begin
                int per;
                per = base_per + JIT[jidx] * jscale;
                jidx = (jidx + 1) % 16;
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                line_pos = lf[0];
                line_neg = lf[1] & ~lf[0];
                line_clk = 1'b1;
                #(per / 2);
                in_pos[wr_cnt % MEMN] = line_pos;
                in_neg[wr_cnt % MEMN] = line_neg;
                wr_cnt++;
                line_clk = 1'b0;
                #(per - per / 2);
            end else begin
                #1;
            end
        end
    end

    always @(posedge out_clk) rise_cnt++;

    // output monitor
    always @(posedge out_clk) begin
        if (mon_en) begin
            #2;
            if (rd_cnt == 0) first_lat = wr_cnt;
            if (chk_stream) begin
                stream_n++;
                if (out_pos !== in_pos[rd_cnt % MEMN] || out_neg !== in_neg[rd_cnt % MEMN])
                    stream_err++;
            end
            est = wr_cnt - rd_cnt - 1;
            if (band_en) begin
                band_n++;
                if (est >= lo_ok && est <= hi_ok && limit_w) band_err++;
                if (est >= hard_hi && !limit_w) band_err++;
                if (est >= half + 2 && !steer_w) band_err++;
                if (est <= half - 2 && steer_w) band_err++;
            end
            if (limit_w) seen_lim = 1;
            if (steer_w) seen_steer = 1;
            rd_cnt++;
        end
    end

    task automatic do_reset(input logic dsel);
        lc_en = 0;
        mon_en = 0;
        #200;
        rst_n = 1'b0;
        depth_sel = dsel;
        wr_cnt = 0; rd_cnt = 0; est = 0; first_lat = -1;
        stream_n = 0; stream_err = 0; band_n = 0; band_err = 0;
        seen_lim = 0; seen_steer = 0;
        if (dsel) begin half = 16; lo_ok = 4; hi_ok = 28; hard_hi = 31; end
        else      begin half = 64; lo_ok = 6; hi_ok = 122; hard_hi = 126; end
        #53;
        rst_n = 1'b1;
    endtask

    // watchdog
    initial begin
        #1_000_000;
        chk(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        realtime t0, t1, t2;
        logic p0, q0;
        int r0;

        // reset state
        #23;
        chk(out_clk == 1'b0, "R3 reset clk", out_clk, 0);
        chk({out_pos, out_neg} == 2'b00, "R3 reset rails", {out_pos, out_neg}, 0);
        chk(limit_w == 1'b0, "R5 reset limit", limit_w, 0);
        chk(steer_w == 1'b0, "R8 reset steer", steer_w, 0);

        // depth 128, jittered line at nominal rate
        do_reset(1'b0);
        base_per = 40; jscale = 1;
        mon_en = 1; chk_stream = 1; band_en = 1; lc_en = 1;
        while (rd_cnt < 400) @(posedge ref_clk);
        chk(stream_err == 0 && stream_n >= 400, "R1 R9 stream depth128", stream_err, 0);
        chk(first_lat >= 64 && first_lat <= 66, "R3 R4 latency depth128", first_lat, 64);
        chk(band_err == 0, "R5 R8 band depth128", band_err, 0);
        chk(seen_lim == 0, "R5 limit low under jitter", seen_lim, 0);

        @(posedge out_clk); t0 = $realtime; #2; p0 = out_pos; q0 = out_neg;
        @(negedge out_clk); t1 = $realtime;
        chk(out_pos == p0 && out_neg == q0, "R2 rails stable while high", {out_pos, out_neg}, {p0, q0});
        @(posedge out_clk); t2 = $realtime;
        chk(int'(t2 - t0) == 40, "R2 output period", int'(t2 - t0), 40);
        chk(int'(t1 - t0) == 20, "R2 output high time", int'(t1 - t0), 20);

        // depth 128, line faster than reads until near full
        seen_lim = 0; seen_steer = 0; band_err = 0; stream_err = 0;
        base_per = 36; jscale = 0;
        while (est < 127) @(posedge ref_clk);
        chk(seen_lim == 1, "R5 limit high near full depth128", seen_lim, 1);
        chk(seen_steer == 1, "R8 steer high above mid", seen_steer, 1);
        chk(band_err == 0, "R5 R8 band fast depth128", band_err, 0);
        chk(stream_err == 0, "R1 order kept at deep fill", stream_err, 0);

        // depth 32, jittered line at nominal rate
        do_reset(1'b1);
        base_per = 40; jscale = 1;
        mon_en = 1; chk_stream = 1; band_en = 1; lc_en = 1;
        while (rd_cnt < 300) @(posedge ref_clk);
        chk(stream_err == 0 && stream_n >= 300, "R1 R9 stream depth32", stream_err, 0);
        chk(first_lat >= 16 && first_lat <= 18, "R3 R4 latency depth32", first_lat, 16);
        chk(band_err == 0, "R5 R8 band depth32", band_err, 0);
        chk(seen_lim == 0, "R4 R5 limit low depth32", seen_lim, 0);

        // depth 32 near full, then recenter, then drain to empty
        seen_lim = 0; band_err = 0;
        base_per = 36; jscale = 0;
        while (est < 33) @(posedge ref_clk);
        chk(band_err == 0, "R5 band fast depth32", band_err, 0);
        lc_en = 0; band_en = 0; chk_stream = 0;
        #50;
        chk(limit_w == 1'b1, "R5 limit high before recenter", limit_w, 1);
        chk(steer_w == 1'b1, "R8 steer high before recenter", steer_w, 1);
        recenter = 1'b1;
        #30;
        recenter = 1'b0;
        #80;
        chk(limit_w == 1'b0, "R6 limit low after recenter", limit_w, 0);
        chk(steer_w == 1'b0, "R6 R8 steer low after recenter", steer_w, 0);
        #1200;
        chk(limit_w == 1'b1, "R5 R10 limit high when empty", limit_w, 1);
        r0 = rise_cnt;
        #300;
        chk(rise_cnt == r0, "R10 output clock stopped when empty", rise_cnt - r0, 0);
        chk(out_clk == 1'b0, "R10 output clock held low", out_clk, 0);

        // bypass
        mon_en = 0;
        bypass = 1'b1;
        for (int i = 0; i < 4; i++) begin
            {line_clk, line_pos, line_neg} = BYP_VEC[i];
            #3;
            chk({out_clk, out_pos, out_neg} == BYP_VEC[i], "R7 bypass passthrough",
                {out_clk, out_pos, out_neg}, BYP_VEC[i]);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule